// File: doc/BRIEF.md
# Start Delimiter Hunter with Preamble Auto-Detect and Search Timeout

This receiver block sits after the descrambler. Once the spreading code has been acquired, it watches the descrambled bit stream for either of two 16-bit start delimiters. The short-preamble delimiter is the bit-reversed form of the long one. When the delimiter is found, the block gives one packet-start pulse and reports which preamble type it matched. Acquisition alone never starts a packet.

Bits are counted only after the descrambler reports that it is initialised. If no delimiter arrives within a bit budget, a timeout pulse ends the search. The budget depends on the preamble type, which is inferred from the polarity of the sync bits: long sync is all ones and short sync is all zeros. After a packet start or a timeout, the block stays quiet until acquisition drops. A drop clears the delimiter window and the timer.

Top module: `sfd_hunter`

## Requirements
- R1: After reset, and while `acq` is low, `pkt_start`, `tmo` and `short_pre` are all 0.
- R2: A bit is accepted only on a cycle where `bit_vld`, `acq` and `dsc_init` are all high and the block is still searching. Each accepted bit enters a 16-bit window, received LSB first. The first-received bit ends up in bit 0. The window starts at all zeros.
- R3: When the window after an accepted bit equals 16'hF3A0 (long delimiter), `pkt_start` is high in the next cycle and `short_pre` becomes 0.
- R4: When the window after an accepted bit equals 16'h05CF (short delimiter, the bit-reverse of 16'hF3A0), `pkt_start` is high in the next cycle and `short_pre` becomes 1.
- R5: `pkt_start` and `tmo` are single-cycle pulses. They are never high together. No `pkt_start` occurs without a delimiter match, whatever the state of `acq`.
- R6: Let k be the number of accepted bits, counting the current one. On the k-th accepted bit without a match, `tmo` pulses in the next cycle if k is at least the limit. The limit is 144 when the bit pushed out of the window by this shift is 1. It is 72 when that bit is 0, which includes the first 16 bits, where the pushed-out bit is 0.
- R7: A match on the same accepted bit at which the limit is reached gives `pkt_start` and no `tmo`.
- R8: After a `pkt_start` or a `tmo`, further bits are ignored and cause no pulse until `acq` goes low.
- R9: When `acq` is low, the window and the bit count are cleared and `short_pre` returns to 0. A delimiter split across an acquisition drop is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Descrambled data bit |
| bit_vld | input | 1 | Strobe marking `bit_in` valid |
| acq | input | 1 | Spreading-code acquisition held |
| dsc_init | input | 1 | Descrambler initialisation complete |
| pkt_start | output | 1 | One-cycle pulse: delimiter found |
| short_pre | output | 1 | 1 = short delimiter matched, 0 = long |
| tmo | output | 1 | One-cycle pulse: search budget spent |

## Verification
The bench sweeps runs of 0 to 40 sync ones ahead of the long delimiter and runs of 0 to 40 sync zeros ahead of the short one. These runs show whether delimiter detection is independent of sync length. Runs of 128 ones and 56 zeros land the match exactly on the limit, which tests match priority. Runs one or two bits longer cross the limit and must time out instead. All-ones, all-zeros and alternating streams with no delimiter tell the 144-bit budget from the 72-bit one. Further streams test that bits sent with the descrambler not ready are ignored, that an acquisition drop mid-delimiter loses the partial match, and that delimiters sent after a result give no second pulse.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int unsigned DLM_W     = 16;
    localparam logic [15:0] LONG_DLM  = 16'hF3A0;
    localparam int unsigned LONG_LIM  = 144;
    localparam int unsigned SHORT_LIM = 72;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_LOCK = 2'd1,
        ST_FAIL = 2'd2
    } hunt_st_e;

    typedef struct packed {
        logic hit_long;
        logic hit_short;
        logic tail;
    } win_stat_t;

    function automatic logic [DLM_W-1:0] bit_rev(input logic [DLM_W-1:0] v);
        logic [DLM_W-1:0] r;
        for (int i = 0; i < DLM_W; i++) begin
            r[i] = v[DLM_W-1-i];
        end
        return r;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sfd_window.sv
module sfd_window
    import sfd_pkg::*;
#(
    parameter int unsigned       W        = DLM_W,
    parameter logic [W-1:0]      PAT_LONG = LONG_DLM
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      shift,
    input  logic      bit_in,
    output win_stat_t stat
);
    localparam logic [W-1:0] PAT_SHORT = bit_rev(PAT_LONG);

    logic [W-1:0] win_q;
    logic [W-1:0] win_nxt;

    assign win_nxt = {bit_in, win_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win_q <= '0;
        end else if (shift) begin
            win_q <= win_nxt;
        end
    end

    always_comb begin
        stat.hit_long  = (win_nxt == PAT_LONG);
        stat.hit_short = (win_nxt == PAT_SHORT);
        stat.tail      = win_q[0];
    end
endmodule

// File: rtl/sfd_timer.sv
module sfd_timer
    import sfd_pkg::*;
#(
    parameter int unsigned LIM_L = LONG_LIM,
    parameter int unsigned LIM_S = SHORT_LIM
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic long_mode,
    output logic expire
);
    localparam int unsigned TOP = max_u(LIM_L, LIM_S);
    localparam int unsigned CW  = $clog2(TOP + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] lim;

    assign cnt_inc = cnt_q + CW'(1);
    assign lim     = long_mode ? CW'(LIM_L) : CW'(LIM_S);
    assign expire  = (cnt_inc >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (step && (cnt_q != CW'(TOP))) begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/sfd_hunter.sv
module sfd_hunter
    import sfd_pkg::*;
#(
    parameter int unsigned  W        = DLM_W,
    parameter logic [W-1:0] PAT_LONG = LONG_DLM,
    parameter int unsigned  LIM_L    = LONG_LIM,
    parameter int unsigned  LIM_S    = SHORT_LIM
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic acq,
    input  logic dsc_init,
    output logic pkt_start,
    output logic short_pre,
    output logic tmo
);
    hunt_st_e  st_q;
    win_stat_t ws;
    logic      take;
    logic      drop;
    logic      expire;

    assign drop = !acq;
    assign take = bit_vld && acq && dsc_init && (st_q == ST_SEEK);

    sfd_window #(.W(W), .PAT_LONG(PAT_LONG)) u_win (
        .clk    (clk),
        .rst    (rst),
        .clr    (drop),
        .shift  (take),
        .bit_in (bit_in),
        .stat   (ws)
    );

    sfd_timer #(.LIM_L(LIM_L), .LIM_S(LIM_S)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .clr       (drop),
        .step      (take),
        .long_mode (ws.tail),
        .expire    (expire)
    );

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            st_q      <= ST_SEEK;
            pkt_start <= 1'b0;
            tmo       <= 1'b0;
            short_pre <= 1'b0;
        end else begin
            pkt_start <= 1'b0;
            tmo       <= 1'b0;
            if (take) begin
                if (ws.hit_long || ws.hit_short) begin
                    pkt_start <= 1'b1;
                    short_pre <= ws.hit_short;
                    st_q      <= ST_LOCK;
                end else if (expire) begin
                    tmo  <= 1'b1;
                    st_q <= ST_FAIL;
                end
            end
        end
    end
endmodule

// File: rtl/sfd_hunter_chk.sv
module sfd_hunter_chk (
    input logic clk,
    input logic rst,
    input logic bit_in,
    input logic bit_vld,
    input logic acq,
    input logic dsc_init,
    input logic pkt_start,
    input logic short_pre,
    input logic tmo
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acq |=> (!pkt_start && !tmo && !short_pre));

    // R5
    excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(pkt_start && tmo));

    // R5
    pkt_single_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_start |=> !pkt_start);

    // R6
    tmo_single_chk: assert property (@(posedge clk) disable iff (rst)
        tmo |=> !tmo);

    // R2
    pkt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_start) |-> $past(bit_vld && acq && dsc_init));

    // R8
    short_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acq && $past(acq) && !pkt_start) |-> $stable(short_pre));
endmodule

bind sfd_hunter sfd_hunter_chk u_chk (.*);

// File: tb/sfd_hunter_tb.sv
module sfd_hunter_tb;
    localparam int CLK_PER = 10;
    localparam logic [15:0] LDLM = 16'hF3A0;
    localparam logic [15:0] SDLM = 16'h05CF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0, bit_vld = 1'b0, acq = 1'b0, dsc_init = 1'b0;
    logic pkt_start, short_pre, tmo;

    int checks = 0;
    int errors = 0;
    bit seq [0:299];
    logic got_p, got_t, got_s;

    always #(CLK_PER/2) clk = ~clk;

    sfd_hunter u_dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .acq(acq), .dsc_init(dsc_init),
        .pkt_start(pkt_start), .short_pre(short_pre), .tmo(tmo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        bit_in = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        got_p = pkt_start;
        got_t = tmo;
        got_s = short_pre;
    endtask

    task automatic restart();
        @(negedge clk);
        acq = 1'b0;
        dsc_init = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 idle", {29'd0, pkt_start, tmo, short_pre}, 0);
        acq = 1'b1;
        dsc_init = 1'b1;
    endtask

    // kind: 0 none, 1 packet long, 2 packet short, 3 timeout
    task automatic run_trial(input int len, input string req);
        logic [15:0] w = '0;
        int ek = 0, ekind = 0, ak = 0, akind = 0;
        for (int k = 1; k <= len && ekind == 0; k++) begin
            bit tl = w[0];
            w = {seq[k-1], w[15:1]};
            if (w == LDLM) begin ek = k; ekind = 1; end
            else if (w == SDLM) begin ek = k; ekind = 2; end
            else if (k >= (tl ? 144 : 72)) begin ek = k; ekind = 3; end
        end
        for (int k = 1; k <= len && akind == 0; k++) begin
            send_bit(seq[k-1]);
            if (got_p) begin ak = k; akind = got_s ? 2 : 1; end
            else if (got_t) begin ak = k; akind = 3; end
        end
        chk({req, " kind"}, akind, ekind);
        chk({req, " index"}, ak, ek);
        if (akind != 0) begin
            @(negedge clk);
            chk("R5 pulse width", {30'd0, pkt_start, tmo}, 0);
            // R8: delimiters after a result are ignored
            for (int i = 0; i < 16; i++) begin
                send_bit(LDLM[i]);
                if (got_p || got_t) chk("R8 ignored long", 1, 0);
            end
            for (int i = 0; i < 16; i++) begin
                send_bit(SDLM[i]);
                if (got_p || got_t) chk("R8 ignored short", 1, 0);
            end
            chk("R8 short_pre held", got_s, (akind == 2) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {29'd0, pkt_start, tmo, short_pre}, 0);
        rst = 1'b0;

        // R3 long delimiter after n ones; 128 hits the limit (R7), 130 past it
        for (int n = 0; n <= 132; n++) begin
            if (n <= 40 || n == 127 || n == 128 || n == 129 || n == 130) begin
                for (int i = 0; i < n; i++) seq[i] = 1'b1;
                for (int i = 0; i < 16; i++) seq[n+i] = LDLM[i];
                restart();
                run_trial(n + 16, (n == 128) ? "R7 long at limit" : "R3 long");
            end
        end
        // R4 short delimiter after n zeros; 56 hits the limit (R7)
        for (int n = 0; n <= 58; n++) begin
            if (n <= 40 || n >= 55) begin
                for (int i = 0; i < n; i++) seq[i] = 1'b0;
                for (int i = 0; i < 16; i++) seq[n+i] = SDLM[i];
                restart();
                run_trial(n + 16, (n == 56) ? "R7 short at limit" : "R4 short");
            end
        end
        // R6 timeouts without delimiter: ones, zeros, alternating, pairs
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 200; i++)
                seq[i] = (p == 0) ? 1'b1 : (p == 1) ? 1'b0 :
                         (p == 2) ? bit'(i % 2) : bit'((i / 2) % 2);
            restart();
            run_trial(200, "R6 timeout");
        end
        // R2: delimiter with descrambler not ready is ignored, timer idle
        restart();
        dsc_init = 1'b0;
        for (int i = 0; i < 16; i++) begin
            send_bit(SDLM[i]);
            if (got_p || got_t) chk("R2 init low ignored", 1, 0);
        end
        dsc_init = 1'b1;
        for (int i = 0; i < 200; i++) seq[i] = 1'b0;
        run_trial(200, "R2 R6 fresh count");
        // R9: delimiter split across an acquisition drop
        restart();
        for (int i = 0; i < 8; i++) send_bit(LDLM[i]);
        @(negedge clk); acq = 1'b0;
        @(negedge clk); acq = 1'b1;
        for (int i = 0; i < 8; i++) seq[i] = LDLM[8+i];
        for (int i = 8; i < 200; i++) seq[i] = 1'b0;
        run_trial(200, "R9 split");
        // R9: short_pre cleared on drop
        for (int i = 0; i < 16; i++) seq[i] = SDLM[i];
        restart();
        run_trial(16, "R4 short bare");
        @(negedge clk); acq = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 short_pre cleared", short_pre, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule